// File: doc/BRIEF.md
# Single-Wire Debug Link Target Bit Transmitter

This block sends a byte from a debug target to a host over one shared, open-drain style wire. The pin is modelled as three signals: a drive enable, a drive value and the sampled level of the line. The target never opens a bit time by itself. For every bit, the host pulls the line low. The target notices that falling edge after a synchronizer and then finishes the bit in one of two ways. For a zero, it keeps the line low for a fixed number of cycles and then drives it high for one cycle. For a one, it drives only that single high cycle. After the high cycle it releases the line.

To send a byte, load it with a one-cycle start strobe while the block is idle. The block then answers the next eight host edges, sending the most significant bit first. It raises a one-cycle done flag when the last bit's drive sequence has ended. Command decoding and the host-to-target direction belong to other blocks.

Top module: `swt_tx`

## Requirements
- R1: While reset is asserted, and when reset is first released, `line_oe`, `busy` and `tx_done` are 0. Asserting `rst_n` in the middle of a bit drops `line_oe` at once.
- R2: `tx_start` is accepted only while `busy` is 0. Acceptance loads `tx_byte` and raises `busy` in the next cycle. A `tx_start` seen while busy leaves the byte being sent unchanged.
- R3: The line passes through a `SYNC_STAGES`-flop synchronizer. The first clock edge at which the line is sampled low is edge k. The target's perceived bit start is edge k+`SYNC_STAGES`, and the drive begins in the cycle that follows that edge.
- R4: For a zero bit, the block drives the line low (`line_oe`=1, `line_out`=0) for exactly `ZERO_LOW_CYC` cycles from the perceived start. With the default of 13 cycles, the line is still low 10 cycles after the start, which is where the host samples it.
- R5: Each bit sequence ends with exactly one cycle of `line_oe`=1, `line_out`=1. For a zero this cycle follows the low period. For a one it follows the perceived start directly. In the next cycle `line_oe` is 0.
- R6: A one bit never drives the line low.
- R7: Bits leave most significant bit first. Bit `DATA_W-1` answers the first host edge after the start.
- R8: `tx_done` is 1 for exactly one cycle. That cycle directly follows the high cycle of the last bit, and `busy` is 0 in it.
- R9: A host falling edge while the block is idle causes no drive, and the next accepted byte is still sent complete from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_start | input | 1 | Start strobe; loads `tx_byte` when idle |
| tx_byte | input | DATA_W | Byte to send |
| line_in | input | 1 | Sampled level of the shared line |
| line_oe | output | 1 | Drive enable for the line (0 = high impedance) |
| line_out | output | 1 | Value driven when `line_oe` is 1 |
| busy | output | 1 | A byte is loaded or being sent |
| tx_done | output | 1 | One-cycle flag after the last bit |

## Verification
The bench builds the block with its defaults: 8 data bits, a 13-cycle zero low time and a two-stage synchronizer. With these values, the exact cycle of the perceived start can be predicted from the host edge. The host sample point at cycle 10 falls inside the low window, and the last low cycle (12) and the high cycle (13) can be probed one by one. A model of the wired line lets the target's own drive feed back into `line_in`, the same way a real shared wire does. The stimulus bytes include all zeros, all ones, alternating bits and patterns that differ only at the ends, so both bit kinds are exercised in every position.

// File: rtl/swt_pkg.sv
package swt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_LOW   = 2'd2,
    ST_PULSE = 2'd3
  } swt_state_e;
endpackage

// File: rtl/swt_rst_sync.sv
module swt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/swt_edge_sync.sv
module swt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/swt_shifter.sv
module swt_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              advance,
  output logic              bit_o,
  output logic              last_o
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load) begin
      sh_d  = data;
      cnt_d = '0;
    end else if (advance) begin
      sh_d  = {sh_q[DATA_W-2:0], 1'b0};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load || advance) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign bit_o  = sh_q[DATA_W-1];
  assign last_o = (cnt_q == CNT_W'(DATA_W-1));
endmodule

// File: rtl/swt_bit_seq.sv
module swt_bit_seq
  import swt_pkg::*;
#(
  parameter int LOW_CYC = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fall,
  input  logic cur_bit,
  input  logic last_bit,
  output logic accept,
  output logic advance,
  output logic busy,
  output logic drv_oe,
  output logic drv_val,
  output logic done
);
  localparam int TMR_W = $clog2(LOW_CYC);

  swt_state_e       st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             done_d;

  always_comb begin
    st_d    = st_q;
    tmr_d   = tmr_q;
    done_d  = 1'b0;
    advance = 1'b0;
    accept  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          accept = 1'b1;
          st_d   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (fall) begin
          if (cur_bit) begin
            st_d = ST_PULSE;
          end else begin
            st_d  = ST_LOW;
            tmr_d = TMR_W'(LOW_CYC - 1);
          end
        end
      end
      ST_LOW: begin
        if (tmr_q == '0) st_d = ST_PULSE;
        else             tmr_d = tmr_q - 1'b1;
      end
      ST_PULSE: begin
        advance = 1'b1;
        if (last_bit) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = ST_WAIT;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
      done  <= 1'b0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      done  <= done_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign drv_oe  = (st_q == ST_LOW) || (st_q == ST_PULSE);
  assign drv_val = (st_q == ST_PULSE);
endmodule

// File: rtl/swt_tx.sv
module swt_tx #(
  parameter int DATA_W       = 8,
  parameter int ZERO_LOW_CYC = 13,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              line_in,
  output logic              line_oe,
  output logic              line_out,
  output logic              busy,
  output logic              tx_done
);
  logic rst_n_s, fall, cur_bit, last_bit, accept, advance;

  swt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  swt_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n_s), .line_in(line_in), .fall_o(fall)
  );

  swt_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .load(accept), .data(tx_byte),
    .advance(advance), .bit_o(cur_bit), .last_o(last_bit)
  );

  swt_bit_seq #(.LOW_CYC(ZERO_LOW_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .start(tx_start), .fall(fall),
    .cur_bit(cur_bit), .last_bit(last_bit), .accept(accept),
    .advance(advance), .busy(busy), .drv_oe(line_oe),
    .drv_val(line_out), .done(tx_done)
  );
endmodule

// File: rtl/swt_tx_chk.sv
module swt_tx_chk #(
  parameter int ZERO_LOW_CYC = 13
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic line_oe,
  input logic line_out,
  input logic tx_done
);
  localparam int LCW = $clog2(ZERO_LOW_CYC + 2);

  logic           low_now, hi_now, low_q;
  logic [LCW-1:0] lowcnt_q;

  assign low_now = line_oe && !line_out;
  assign hi_now  = line_oe && line_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q    <= 1'b0;
      lowcnt_q <= '0;
    end else begin
      low_q    <= low_now;
      lowcnt_q <= low_now ? lowcnt_q + 1'b1 : '0;
    end
  end

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !line_oe) else $error("idle drive"); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) tx_done |=> !tx_done) else $error("done width"); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) tx_done |-> !busy) else $error("done while busy"); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) hi_now |=> !line_oe) else $error("pulse width"); // R5
  AST_LOW_ENDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (low_q && !low_now) |-> hi_now) else $error("no speedup"); // R5
  AST_ZERO_LOW_LEN: assert property (@(posedge clk) disable iff (!rst_n) (low_q && !low_now) |-> (lowcnt_q == LCW'(ZERO_LOW_CYC))) else $error("low length"); // R4
endmodule

bind swt_tx swt_tx_chk #(.ZERO_LOW_CYC(ZERO_LOW_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .line_oe(line_oe),
  .line_out(line_out), .tx_done(tx_done)
);

// File: tb/sim_swt_tx.sv
`timescale 1ns/1ps
module sim_swt_tx;
  localparam int DW = 8;
  localparam int NV = 5;
  localparam logic [DW-1:0] VEC [NV] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};

  logic clk = 1'b0;
  logic rst_n, tx_start, host_low;
  logic [DW-1:0] tx_byte;
  logic line_in, line_oe, line_out, busy, tx_done;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  assign line_in = host_low ? 1'b0 : (line_oe ? line_out : 1'b1);

  swt_tx u0 (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_byte(tx_byte),
    .line_in(line_in), .line_oe(line_oe), .line_out(line_out),
    .busy(busy), .tx_done(tx_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start_byte(input logic [DW-1:0] b);
    tx_start = 1'b1;
    tx_byte  = b;
    step();
    tx_start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
  endtask

  // Host opens a bit; checks the target's answer cycle by cycle.
  task automatic host_bit(input bit exp, input bit last);
    host_low = 1'b1;
    step();                 // edge k
    step();                 // edge k+1
    host_low = 1'b0;
    step();                 // edge S = k+2, now in cycle after S
    if (exp) begin
      chk(line_oe && line_out, "R3 R5 R7 one: pulse after start", {line_oe, line_out}, 3);
      step();
      chk(!line_oe, "R5 R6 one: released", line_oe, 0);
    end else begin
      chk(line_oe && !line_out, "R3 R7 zero: low after start", {line_oe, line_out}, 2);
      repeat (9) step();
      chk(line_oe && !line_out, "R4 zero: low at host sample", {line_oe, line_out}, 2);
      repeat (3) step();
      chk(line_oe && !line_out, "R4 zero: last low cycle", {line_oe, line_out}, 2);
      step();
      chk(line_oe && line_out, "R5 zero: speedup pulse", {line_oe, line_out}, 3);
      step();
      chk(!line_oe, "R5 zero: released", line_oe, 0);
    end
    if (last) begin
      chk(tx_done && !busy, "R8 done after last bit", {tx_done, busy}, 2);
      step();
      chk(!tx_done, "R8 done one cycle", tx_done, 0);
    end else begin
      chk(!tx_done && busy, "R8 no early done", {tx_done, busy}, 1);
    end
    repeat (3) step();
  endtask

  task automatic send_expect(input logic [DW-1:0] b);
    for (int i = DW - 1; i >= 0; i--) host_bit(b[i], i == 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog R8 act=0 exp=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_start = 1'b0; tx_byte = '0; host_low = 1'b0;
    @(negedge clk);
    chk(!line_oe && !busy && !tx_done, "R1 in reset", {line_oe, busy, tx_done}, 0);
    repeat (2) step();
    rst_n = 1'b1;
    repeat (5) step();
    chk(!line_oe && !busy && !tx_done, "R1 after release", {line_oe, busy, tx_done}, 0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      start_byte(VEC[v]);
      send_expect(VEC[v]);
    end

    // R9: host edge while idle
    host_low = 1'b1;
    step(); step();
    host_low = 1'b0;
    for (int i = 0; i < 16; i++) begin
      step();
      if (line_oe || busy) begin
        chk(1'b0, "R9 idle edge drove", {line_oe, busy}, 0);
        break;
      end
    end
    chk(!line_oe && !busy, "R9 idle edge ignored", {line_oe, busy}, 0);
    start_byte(8'h6B);
    send_expect(8'h6B);

    // R2: start while busy ignored
    start_byte(8'hF0);
    tx_start = 1'b1;
    tx_byte  = 8'h0F;
    step();
    tx_start = 1'b0;
    send_expect(8'hF0);

    // R1: reset mid zero bit
    start_byte(8'h00);
    host_low = 1'b1;
    step(); step();
    host_low = 1'b0;
    step(); step();
    chk(line_oe && !line_out, "R1 in low before reset", {line_oe, line_out}, 2);
    rst_n = 1'b0;
    #0.5;
    chk(!line_oe && !busy, "R1 reset drops drive", {line_oe, busy}, 0);
    step();
    rst_n = 1'b1;
    repeat (5) step();
    chk(!line_oe && !busy && !tx_done, "R1 idle after mid reset", {line_oe, busy, tx_done}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule